// File: doc/BRIEF.md
# Three-Bank GPIO Controller with Per-Pin Interrupts

This block is a general-purpose I/O controller with three banks of 30 pins each, reached through a simple 32-bit register bus. Each pin can be claimed for GPIO use, set as an input or an output, and driven from a stored output value. Software reads the pad level back after it has passed through a two-flop synchroniser.

Every input pin also has its own interrupt source. A per-pin type bit picks level or edge sensing, and a per-pin polarity bit picks high/rising or low/falling. A detected event sets a sticky pending bit. Software clears that bit by writing zero to it. Each bank raises one combined interrupt line when any pin is an input, is pending and is enabled. Only the 30 pin bits take part; bits 31:30 of each register never affect a pad or an interrupt.

The register layout is arranged by group. Each group holds one word per bank, and the three words sit next to each other. The word address is the group base plus 4 times the bank index. The group bases are: direction 0x00, polarity 0x20, sense type 0x30, interrupt enable 0x40, pending status 0x50, ownership 0x60, input level 0x70 and output value 0x80.

Top module: `pgb_top`

## Requirements
- R1: After reset, every direction bit is 1 (input), and every enable, ownership and output-value bit is 0. All interrupt lines and pad output enables are low.
- R2: A word at address group base + 4*b is bank b's register, for b from 0 to 2. An access is ignored and reads 0 when the bank index is 3, when address bits 1:0 are nonzero, or when the group base is not one of the eight listed. A write to the input-level group has no effect.
- R3: Bits 31:30 of the direction, polarity, type, enable, ownership and output words can be stored and read back, but they never drive a pad or an interrupt. Bits 31:30 of the status and input-level words always read 0.
- R4: For each pin p in bank b, the pad output enable is ownership[p] AND NOT direction[p]. The pad output value is output-value bit p, and the ownership pin mirrors ownership bit p.
- R5: A pad level appears in the input-level word after two clock edges. The value still reads old after one edge.
- R6: With the type bit set to 1 (edge), polarity 1 sets the pending bit on a rising edge of the synchronised input and polarity 0 sets it on a falling edge. The bit is set on the third clock edge after the pad changes. An edge in the other direction sets nothing.
- R7: With the type bit set to 0 (level), the pending bit is set on every cycle in which the synchronised input equals the polarity bit. It therefore stays set across a clear while the level is still active.
- R8: Writing the status word clears each bit written as 0 and keeps each bit written as 1. An event on the same cycle as a clear leaves the bit set.
- R9: A bank's interrupt line is high exactly when some pin among bits 29:0 has direction 1, pending 1 and enable 1. A pin switched to output stops contributing to the interrupt, and its pending bit is kept.
- R10: Each bank's interrupt line depends only on that bank's own pins and registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address of the word |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the address |
| pad_in | input | 90 | Pad levels, bank b pin p at bit 30*b+p |
| pad_out | output | 90 | Pad output values |
| pad_oe | output | 90 | Pad output enables |
| pad_own | output | 90 | 1 = pad is owned by the GPIO function |
| irq_out | output | 3 | One combined interrupt per bank |

## Verification
The hardest case to reach is a clear landing on the same cycle as a fresh event, because in edge mode the two have to line up exactly. The stimulus gets there through level mode instead. There the event repeats on every cycle, so a zero-write to a pin whose level is still active must lose to the event, and the bit must read back as set. Edge timing is checked cycle by cycle: the pad is changed on a falling clock edge, the interrupt is sampled after the second rising edge and found still low, and then it is sampled after the third rising edge.

// File: rtl/pgb_pkg.sv
package pgb_pkg;
  localparam int REG_W  = 32;
  localparam int ADDR_W = 8;

  typedef enum logic [3:0] {
    GRP_DIR  = 4'h0,
    GRP_POL  = 4'h2,
    GRP_TYP  = 4'h3,
    GRP_EN   = 4'h4,
    GRP_STS  = 4'h5,
    GRP_OWN  = 4'h6,
    GRP_DIN  = 4'h7,
    GRP_DOUT = 4'h8
  } grp_e;

  function automatic logic grp_known(input logic [3:0] g);
    return (g == 4'h0) || ((g >= 4'h2) && (g <= 4'h8));
  endfunction
endpackage

// File: rtl/pgb_sync.sv
module pgb_sync #(
  parameter int W = 30
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pgb_detect.sv
module pgb_detect #(
  parameter int PINS = 30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PINS-1:0] cur,
  input  logic [PINS-1:0] pol,
  input  logic [PINS-1:0] typ,
  output logic [PINS-1:0] evt
);
  logic [PINS-1:0] prev_q;

  // A pin fires when its level matches the polarity. In edge mode it must also have just changed.
  function automatic logic [PINS-1:0] sense(input logic [PINS-1:0] c, p, pl, ty);
    return ~(c ^ pl) & (~ty | (c ^ p));
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cur;
  end

  assign evt = sense(cur, prev_q, pol, typ);

  AST_EDGE_NEEDS_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    ((evt & typ & ~(cur ^ prev_q)) == '0)); // R6
endmodule

// File: rtl/pgb_bank.sv
module pgb_bank
  import pgb_pkg::*;
#(
  parameter int PINS = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  grp_e             wr_grp,
  input  logic [REG_W-1:0] wr_data,
  input  logic [PINS-1:0]  pad_in,
  output logic [REG_W-1:0] dir_q,
  output logic [REG_W-1:0] pol_q,
  output logic [REG_W-1:0] typ_q,
  output logic [REG_W-1:0] en_q,
  output logic [REG_W-1:0] sts_q,
  output logic [REG_W-1:0] own_q,
  output logic [REG_W-1:0] dout_q,
  output logic [PINS-1:0]  din_s,
  output logic             irq
);
  localparam int PAD_W = REG_W - PINS;
  localparam logic [REG_W-1:0] PIN_MASK = {{PAD_W{1'b0}}, {PINS{1'b1}}};

  logic [PINS-1:0]  evt;
  logic [REG_W-1:0] evt_w;
  logic             sts_wr;
  logic [REG_W-1:0] pend;

  // Write-zero clears the bit. A fresh event is ORed in afterwards, so it wins over the clear.
  function automatic logic [REG_W-1:0] sts_update(input logic [REG_W-1:0] s, e,
                                                  input logic w,
                                                  input logic [REG_W-1:0] keep);
    return (w ? (s & keep) : s) | e;
  endfunction

  function automatic logic [REG_W-1:0] pending(input logic [REG_W-1:0] d, s, m);
    return d & s & m & PIN_MASK;
  endfunction

  pgb_sync #(.W(PINS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (din_s)
  );

  pgb_detect #(.PINS(PINS)) u_det (
    .clk  (clk),
    .rst_n(rst_n),
    .cur  (din_s),
    .pol  (pol_q[PINS-1:0]),
    .typ  (typ_q[PINS-1:0]),
    .evt  (evt)
  );

  assign evt_w  = {{PAD_W{1'b0}}, evt};
  assign sts_wr = wr_en && (wr_grp == GRP_STS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q  <= '1;
      pol_q  <= '0;
      typ_q  <= '0;
      en_q   <= '0;
      sts_q  <= '0;
      own_q  <= '0;
      dout_q <= '0;
    end else begin
      if (wr_en) begin
        case (wr_grp)
          GRP_DIR:  dir_q  <= wr_data;
          GRP_POL:  pol_q  <= wr_data;
          GRP_TYP:  typ_q  <= wr_data;
          GRP_EN:   en_q   <= wr_data;
          GRP_OWN:  own_q  <= wr_data;
          GRP_DOUT: dout_q <= wr_data;
          default:  ;
        endcase
      end
      sts_q <= sts_update(sts_q, evt_w, sts_wr, wr_data);
    end
  end

  assign pend = pending(dir_q, sts_q, en_q);
  assign irq  = |pend;

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    sts_wr |=> ((sts_q & ~$past(evt_w) & ~$past(wr_data)) == '0)); // R8
  AST_EVENT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((sts_q[PINS-1:0] & $past(evt)) == $past(evt))); // R7
  AST_NO_SPONTANEOUS_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q & ~$past(sts_q) & ~$past(evt_w)) == '0)); // R6
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q[PINS-1:0] != '0)); // R9
endmodule

// File: rtl/pgb_top.sv
module pgb_top
  import pgb_pkg::*;
#(
  parameter int NUM_BANKS = 3,
  parameter int PINS      = 30
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bus_sel,
  input  logic                      bus_we,
  input  logic [ADDR_W-1:0]         bus_addr,
  input  logic [REG_W-1:0]          bus_wdata,
  output logic [REG_W-1:0]          bus_rdata,
  input  logic [NUM_BANKS*PINS-1:0] pad_in,
  output logic [NUM_BANKS*PINS-1:0] pad_out,
  output logic [NUM_BANKS*PINS-1:0] pad_oe,
  output logic [NUM_BANKS*PINS-1:0] pad_own,
  output logic [NUM_BANKS-1:0]      irq_out
);
  localparam int IDX_W = 2;
  localparam int PAD_W = REG_W - PINS;

  grp_e             grp;
  logic [IDX_W-1:0] idx;
  logic             hit;
  logic [NUM_BANKS-1:0] bank_hit;

  logic [REG_W-1:0] dir_a  [NUM_BANKS];
  logic [REG_W-1:0] pol_a  [NUM_BANKS];
  logic [REG_W-1:0] typ_a  [NUM_BANKS];
  logic [REG_W-1:0] en_a   [NUM_BANKS];
  logic [REG_W-1:0] sts_a  [NUM_BANKS];
  logic [REG_W-1:0] own_a  [NUM_BANKS];
  logic [REG_W-1:0] dout_a [NUM_BANKS];
  logic [PINS-1:0]  din_a  [NUM_BANKS];

  assign grp = grp_e'(bus_addr[ADDR_W-1:4]);
  assign idx = bus_addr[3:2];
  assign hit = bus_sel && (bus_addr[1:0] == 2'b00) && grp_known(bus_addr[ADDR_W-1:4])
               && (int'(idx) < NUM_BANKS);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = hit && (int'(idx) == b);

    pgb_bank #(.PINS(PINS)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (bank_hit[b] && bus_we),
      .wr_grp (grp),
      .wr_data(bus_wdata),
      .pad_in (pad_in[b*PINS +: PINS]),
      .dir_q  (dir_a[b]),
      .pol_q  (pol_a[b]),
      .typ_q  (typ_a[b]),
      .en_q   (en_a[b]),
      .sts_q  (sts_a[b]),
      .own_q  (own_a[b]),
      .dout_q (dout_a[b]),
      .din_s  (din_a[b]),
      .irq    (irq_out[b])
    );

    assign pad_out[b*PINS +: PINS] = dout_a[b][PINS-1:0];
    assign pad_own[b*PINS +: PINS] = own_a[b][PINS-1:0];
    assign pad_oe[b*PINS +: PINS]  = own_a[b][PINS-1:0] & ~dir_a[b][PINS-1:0];
  end

  always_comb begin
    bus_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) begin
        case (grp)
          GRP_DIR:  bus_rdata = dir_a[b];
          GRP_POL:  bus_rdata = pol_a[b];
          GRP_TYP:  bus_rdata = typ_a[b];
          GRP_EN:   bus_rdata = en_a[b];
          GRP_STS:  bus_rdata = sts_a[b];
          GRP_OWN:  bus_rdata = own_a[b];
          GRP_DIN:  bus_rdata = {{PAD_W{1'b0}}, din_a[b]};
          GRP_DOUT: bus_rdata = dout_a[b];
          default:  bus_rdata = '0;
        endcase
      end
    end
  end

  AST_BAD_BANK_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && (int'(bus_addr[3:2]) >= NUM_BANKS)) |-> (bus_rdata == '0)); // R2
endmodule

// File: tb/tb_pgb_top.sv
module tb_pgb_top;
  localparam int NB = 3;
  localparam int NP = 30;
  localparam logic [3:0] G_DIR = 4'h0, G_POL = 4'h2, G_TYP = 4'h3, G_EN = 4'h4,
                         G_STS = 4'h5, G_OWN = 4'h6, G_DIN = 4'h7, G_DOUT = 4'h8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_sel = 1'b0, bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [NB*NP-1:0] pad_in = '0;
  logic [NB*NP-1:0] pad_out, pad_oe, pad_own;
  logic [NB-1:0] irq_out;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pgb_top dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .pad_own(pad_own),
    .irq_out(irq_out)
  );

  function automatic logic [7:0] ra(input logic [3:0] g, input int b);
    return {g, b[1:0], 2'b00};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic set_pad(input int b, input int p, input logic v);
    @(negedge clk);
    pad_in[b*NP+p] = v;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1", "irq_out", 32'(irq_out), 32'h0);
    chk("R1", "pad_oe", 32'(|pad_oe), 32'h0);
    rd(ra(G_DIR, 0), d);  chk("R1", "dir b0", d, 32'hFFFF_FFFF);
    rd(ra(G_EN, 2), d);   chk("R1", "en b2", d, 32'h0);
    rd(ra(G_OWN, 1), d);  chk("R1", "own b1", d, 32'h0);
    rd(ra(G_DOUT, 0), d); chk("R1", "dout b0", d, 32'h0);
  endtask

  task automatic t_addr_map;
    logic [31:0] d;
    wr(ra(G_DOUT, 1), 32'h1234_5678);
    rd(ra(G_DOUT, 1), d); chk("R2", "dout b1", d, 32'h1234_5678);
    rd(ra(G_DOUT, 0), d); chk("R2", "dout b0 untouched", d, 32'h0);
    rd(ra(G_DOUT, 2), d); chk("R2", "dout b2 untouched", d, 32'h0);
    chk("R4", "pad_out b1", 32'(pad_out[NP +: NP]), 32'h1234_5678);
    wr(ra(G_DOUT, 3), 32'hFFFF_FFFF);
    rd(ra(G_DOUT, 3), d); chk("R2", "bank3 reads zero", d, 32'h0);
    rd(ra(G_DOUT, 0), d); chk("R2", "bank3 write ignored b0", d, 32'h0);
    rd(ra(G_DOUT, 2), d); chk("R2", "bank3 write ignored b2", d, 32'h0);
    wr(ra(G_DIN, 0), 32'hFFFF_FFFF);
    rd(ra(G_DIN, 0), d);  chk("R2", "din write ignored", d, 32'h0);
    rd(8'h81, d);         chk("R2", "misaligned reads zero", d, 32'h0);
    wr(8'h10, 32'hFFFF_FFFF);
    rd(8'h10, d);         chk("R2", "unmapped group reads zero", d, 32'h0);
    wr(ra(G_DOUT, 0), 32'hFFFF_FFFF);
    rd(ra(G_DOUT, 0), d); chk("R3", "upper bits stored", d, 32'hFFFF_FFFF);
    chk("R3", "pad_out b0 only 30 pins", 32'(pad_out[0 +: NP]), 32'h3FFF_FFFF);
    wr(ra(G_DOUT, 0), 32'h0);
  endtask

  task automatic t_pads;
    wr(ra(G_OWN, 1), 32'h0000_000F);
    wr(ra(G_DIR, 1), 32'hFFFF_FFFC);
    chk("R4", "pad_oe b1", 32'(pad_oe[NP +: NP]), 32'h3);
    chk("R4", "pad_own b1", 32'(pad_own[NP +: NP]), 32'hF);
    chk("R4", "pad_oe b0", 32'(pad_oe[0 +: NP]), 32'h0);
  endtask

  task automatic t_din;
    logic [31:0] d;
    set_pad(2, 5, 1'b1);
    edges(1);
    rd(ra(G_DIN, 2), d); chk("R5", "din after one edge", d, 32'h0);
    edges(1);
    rd(ra(G_DIN, 2), d); chk("R5", "din after two edges", d, 32'h20);
  endtask

  task automatic t_edge_rise;
    logic [31:0] d;
    wr(ra(G_TYP, 0), 32'h8);
    wr(ra(G_POL, 0), 32'h8);
    wr(ra(G_EN, 0), 32'h8);
    edges(3);
    wr(ra(G_STS, 0), ~32'h8);
    rd(ra(G_STS, 0), d); chk("R8", "clear pin3", d & 32'h8, 32'h0);
    chk("R6", "irq0 idle", 32'(irq_out[0]), 32'h0);
    set_pad(0, 3, 1'b1);
    edges(2); chk("R6", "rise not yet", 32'(irq_out[0]), 32'h0);
    edges(1); chk("R6", "rise third edge", 32'(irq_out[0]), 32'h1);
    set_pad(0, 3, 1'b0);
    edges(4);
    wr(ra(G_STS, 0), ~32'h8);
    rd(ra(G_STS, 0), d); chk("R6", "fall ignored, cleared", d & 32'h8, 32'h0);
    chk("R8", "irq0 after clear", 32'(irq_out[0]), 32'h0);
  endtask

  task automatic t_edge_fall;
    wr(ra(G_TYP, 0), 32'h18);
    wr(ra(G_EN, 0), 32'h18);
    set_pad(0, 4, 1'b1);
    edges(4);
    wr(ra(G_STS, 0), ~32'h18);
    chk("R6", "rise ignored pol0", 32'(irq_out[0]), 32'h0);
    set_pad(0, 4, 1'b0);
    edges(2); chk("R6", "fall not yet", 32'(irq_out[0]), 32'h0);
    edges(1); chk("R6", "fall third edge", 32'(irq_out[0]), 32'h1);
    wr(ra(G_STS, 0), ~32'h18);
    chk("R8", "fall cleared", 32'(irq_out[0]), 32'h0);
  endtask

  task automatic t_level_and_mask;
    logic [31:0] d;
    wr(ra(G_POL, 1), 32'h80);
    wr(ra(G_EN, 1), 32'h80);
    wr(ra(G_STS, 1), ~32'h80);
    chk("R7", "level idle", 32'(irq_out[1]), 32'h0);
    set_pad(1, 7, 1'b1);
    edges(3); chk("R7", "level active", 32'(irq_out[1]), 32'h1);
    wr(ra(G_STS, 1), ~32'h80);
    rd(ra(G_STS, 1), d); chk("R8", "event wins over clear", d & 32'h80, 32'h80);
    wr(ra(G_DIR, 1), 32'hFFFF_FF7C);
    chk("R9", "output pin masked", 32'(irq_out[1]), 32'h0);
    rd(ra(G_STS, 1), d); chk("R9", "status kept", d & 32'h80, 32'h80);
    wr(ra(G_DIR, 1), 32'hFFFF_FFFC);
    chk("R9", "input again", 32'(irq_out[1]), 32'h1);
    set_pad(1, 7, 1'b0);
    edges(3);
    wr(ra(G_STS, 1), ~32'h80);
    rd(ra(G_STS, 1), d); chk("R7", "level gone, clear sticks", d & 32'h80, 32'h0);
    wr(ra(G_EN, 1), 32'h0);
  endtask

  task automatic t_upper_bits;
    logic [31:0] d;
    wr(ra(G_EN, 2), 32'hC000_0000);
    wr(ra(G_STS, 2), 32'hFFFF_FFFF);
    rd(ra(G_EN, 2), d);  chk("R3", "en upper stored", d, 32'hC000_0000);
    chk("R3", "upper en no irq", 32'(irq_out[2]), 32'h0);
    rd(ra(G_STS, 2), d); chk("R3", "sts upper zero", d & 32'hC000_0000, 32'h0);
    rd(ra(G_DIN, 2), d); chk("R3", "din upper zero", d & 32'hC000_0000, 32'h0);
  endtask

  task automatic t_banks_apart;
    wr(ra(G_TYP, 2), 32'h1);
    wr(ra(G_POL, 2), 32'h1);
    wr(ra(G_EN, 2), 32'h1);
    edges(3);
    wr(ra(G_STS, 2), ~32'h1);
    chk("R10", "all quiet", 32'(irq_out), 32'h0);
    set_pad(2, 0, 1'b1);
    edges(3);
    chk("R10", "only bank2 fires", 32'(irq_out), 32'h4);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_addr_map();
    t_pads();
    t_din();
    t_edge_rise();
    t_edge_fall();
    t_level_and_mask();
    t_upper_bits();
    t_banks_apart();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule